// File: doc/BRIEF.md
# Quadrature Downconverter with Rate-by-Five Decimation

This block takes a stream of real, signed 16-bit samples of an intermediate-frequency signal and produces a complex baseband stream at one fifth of the input rate. The samples arrive at 48 kHz and the signal sits at 15 kHz. Every accepted sample is multiplied by a cosine carrier to form the in-phase (I) product and by a sine carrier to form the quadrature (Q) product. The carrier comes from a sixteen-entry signed table. A four-bit phase index walks that table, and because 15/48 equals 5/16, the index moves forward by five on each sample.

Each product is a full 32-bit signed value. The block keeps only its upper Q15 word, with saturation. Each channel then adds up five consecutive products in a wide accumulator. The block scales that sum down, clips it back to 16 bits, and sends out I and Q together with a single valid pulse, so the output rate is 9.6 kHz. The upstream source marks each sample with a qualifier. Cycles without that qualifier leave every piece of state unchanged.

Top module: `iq_downconv`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_i`/`out_q` are 0. The carrier phase index and the decimation counter both restart at zero, so the first sample accepted after reset uses table entry 0 for sine.
- R2: The carrier table entry k holds round(32767·sin(2πk/16)), except entry 12, which holds −32768. The phase index starts at 0 and advances by 5 modulo 16 on each accepted sample. The cosine is read at index (phase + 4) mod 16.
- R3: Each mixer forms the signed 32-bit product of the sample and its carrier and keeps that product arithmetically shifted right by 15. A result above 32767 saturates to 32767. For example, −32768 × −32768 gives 32767 and does not wrap.
- R4: `out_i` is built from the cosine product and `out_q` from the sine product.
- R5: `out_valid` is a one-cycle pulse that appears in the cycle after every fifth accepted sample. Two pulses can never occur in consecutive cycles.
- R6: At each pulse, each output equals the sum of that channel's five mixer results since the previous pulse, arithmetically shifted right by 1 (floor) and clipped to the range −32768..32767.
- R7: Between pulses, `out_i` and `out_q` hold the values they took at the last pulse.
- R8: A cycle with `in_valid` low advances neither the phase nor the decimation count and adds nothing to the sums, whatever `in_sample` carries.
- R9: A five-sample sum that falls below −65536 drives the output to −32768. A sum above 65535 drives it to 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_sample` for this cycle |
| in_sample | input | 16 | Signed IF sample |
| out_valid | output | 1 | One-cycle pulse marking a new I/Q pair |
| out_i | output | 16 | Signed in-phase baseband sample |
| out_q | output | 16 | Signed quadrature baseband sample |

## Verification
If the phase index holds a wrong value, the pair that follows carries the wrong carrier weights, and this shows at the next pulse, at most five accepted samples later. A single sample placed at a known position tells a cosine offset fault apart from an I/Q swap. A fault in the decimation counter moves the pulse away from the fifth sample, which shows as soon as a pulse appears early or fails to appear. Accumulator or clipping faults show only in the value delivered at the pulse that closes the affected group. For this reason the extreme-magnitude groups and the −32768 × −32768 product are each driven on purpose.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  localparam int SMP_W   = 16;
  localparam int PH_W    = 4;
  localparam int NCH     = 2;
  localparam int CH_I    = 0;
  localparam int CH_Q    = 1;
  localparam int COS_OFS = 4;

  // Q15 sine over one cycle in 16 steps; negative peak uses the full code -32768
  function automatic logic signed [SMP_W-1:0] sin_lut(input logic [PH_W-1:0] k);
    logic signed [SMP_W-1:0] v;
    case (k)
      4'd0:  v = 16'sd0;
      4'd1:  v = 16'sd12539;
      4'd2:  v = 16'sd23170;
      4'd3:  v = 16'sd30273;
      4'd4:  v = 16'sd32767;
      4'd5:  v = 16'sd30273;
      4'd6:  v = 16'sd23170;
      4'd7:  v = 16'sd12539;
      4'd8:  v = 16'sd0;
      4'd9:  v = -16'sd12539;
      4'd10: v = -16'sd23170;
      4'd11: v = -16'sd30273;
      4'd12: v = -16'sd32768;
      4'd13: v = -16'sd30273;
      4'd14: v = -16'sd23170;
      default: v = -16'sd12539;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/iqd_carrier.sv
module iqd_carrier
  import iqd_pkg::*;
#(
  parameter int STEP = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  output logic signed [SMP_W-1:0] sin_o,
  output logic signed [SMP_W-1:0] cos_o
);
  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (adv) ph_d = ph_q + PH_W'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign sin_o = sin_lut(ph_q);
  assign cos_o = sin_lut(ph_q + PH_W'(COS_OFS));
endmodule

// File: rtl/iqd_mixer.sv
module iqd_mixer
  import iqd_pkg::*;
(
  input  logic signed [SMP_W-1:0] smp,
  input  logic signed [SMP_W-1:0] car,
  output logic signed [SMP_W-1:0] mix
);
  localparam int PW = 2 * SMP_W;

  logic signed [PW-1:0] smp_x, car_x, prod, shr;
  logic                 fits;

  assign smp_x = {{SMP_W{smp[SMP_W-1]}}, smp};
  assign car_x = {{SMP_W{car[SMP_W-1]}}, car};
  assign prod  = smp_x * car_x;
  assign shr   = prod >>> (SMP_W - 1);
  assign fits  = (&shr[PW-1:SMP_W-1]) | ~(|shr[PW-1:SMP_W-1]);

  always_comb begin
    if (fits)              mix = shr[SMP_W-1:0];
    else if (shr[PW-1])    mix = {1'b1, {(SMP_W-1){1'b0}}};
    else                   mix = {1'b0, {(SMP_W-1){1'b1}}};
  end
endmodule

// File: rtl/iqd_decim.sv
module iqd_decim
  import iqd_pkg::*;
#(
  parameter int ACC_W = 19,
  parameter int SHIFT = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    dump,
  input  logic signed [SMP_W-1:0] mix,
  output logic signed [SMP_W-1:0] y
);
  logic signed [ACC_W-1:0] acc_q, acc_d, sum, scaled;
  logic signed [SMP_W-1:0] y_q, y_d, clip;
  logic                    fits;

  assign sum    = acc_q + {{(ACC_W-SMP_W){mix[SMP_W-1]}}, mix};
  assign scaled = sum >>> SHIFT;
  assign fits   = (&scaled[ACC_W-1:SMP_W-1]) | ~(|scaled[ACC_W-1:SMP_W-1]);

  always_comb begin
    if (fits)                clip = scaled[SMP_W-1:0];
    else if (scaled[ACC_W-1]) clip = {1'b1, {(SMP_W-1){1'b0}}};
    else                     clip = {1'b0, {(SMP_W-1){1'b1}}};
  end

  always_comb begin
    acc_d = acc_q;
    y_d   = y_q;
    if (en) begin
      if (dump) begin
        acc_d = '0;
        y_d   = clip;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      y_q   <= '0;
    end else begin
      acc_q <= acc_d;
      y_q   <= y_d;
    end
  end

  assign y = y_q;
endmodule

// File: rtl/iq_downconv.sv
module iq_downconv
  import iqd_pkg::*;
#(
  parameter int DEC_RATIO  = 5,
  parameter int PHASE_STEP = 5,
  parameter int DEC_SHIFT  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_sample,
  output logic        out_valid,
  output logic [15:0] out_i,
  output logic [15:0] out_q
);
  localparam int CNT_W = (DEC_RATIO > 1) ? $clog2(DEC_RATIO) : 1;
  localparam int ACC_W = SMP_W + $clog2(DEC_RATIO + 1);

  logic signed [SMP_W-1:0] car_sin, car_cos;
  logic signed [SMP_W-1:0] car_v [NCH];
  logic signed [SMP_W-1:0] mix_v [NCH];
  logic signed [SMP_W-1:0] dec_v [NCH];
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic                    last, vld_q, vld_d;

  iqd_carrier #(.STEP(PHASE_STEP)) u_car (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (in_valid),
    .sin_o (car_sin),
    .cos_o (car_cos)
  );

  assign car_v[CH_I] = car_cos;
  assign car_v[CH_Q] = car_sin;

  assign last = (cnt_q == CNT_W'(DEC_RATIO - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (in_valid) cnt_d = last ? '0 : cnt_q + 1'b1;
    vld_d = in_valid & last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    iqd_mixer u_mix (
      .smp (in_sample),
      .car (car_v[ch]),
      .mix (mix_v[ch])
    );
    iqd_decim #(.ACC_W(ACC_W), .SHIFT(DEC_SHIFT)) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .dump  (last),
      .mix   (mix_v[ch]),
      .y     (dec_v[ch])
    );
  end

  assign out_valid = vld_q;
  assign out_i     = dec_v[CH_I];
  assign out_q     = dec_v[CH_Q];
endmodule

// File: rtl/iqd_checker.sv
module iqd_checker #(
  parameter int DEC_RATIO = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_sample,
  input logic        out_valid,
  input logic [15:0] out_i,
  input logic [15:0] out_q,
  input logic [15:0] car_sin,
  input logic [15:0] mix_q
);
  localparam int SW = $clog2(DEC_RATIO + 2) + 1;
  logic [SW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen <= '0;
    else if (out_valid) seen <= in_valid ? SW'(1) : '0;
    else if (in_valid)  seen <= seen + 1'b1;
  end

  // R5: single-cycle pulse
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5: pulse follows an accepted sample
  a_r5_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R5, R8: exactly DEC_RATIO accepted samples per pulse
  a_r5_group_size: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen == SW'(DEC_RATIO)));

  // R7: outputs hold between pulses
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));

  // R3: negative-full-scale squared saturates on the sine mixer
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sample == 16'h8000 && car_sin == 16'h8000) |-> (mix_q == 16'h7FFF));
endmodule

bind iq_downconv iqd_checker #(.DEC_RATIO(DEC_RATIO)) u_iqd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q),
  .car_sin   (car_sin),
  .mix_q     (mix_v[1])
);

// File: tb/test_iq_downconv.sv
module test_iq_downconv;
  logic        clk, rst_n, in_valid;
  logic [15:0] in_sample;
  logic        out_valid;
  logic [15:0] out_i, out_q;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int m_ph, m_cnt, m_acc_i, m_acc_q, e_i, e_q;
  bit e_v;

  iq_downconv i_iq_downconv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // {valid, sample}
  localparam logic [16:0] VEC [24] = '{
    {1'b1, 16'h4000}, {1'b1, 16'h1234}, {1'b1, 16'hC000}, {1'b0, 16'h7FFF},
    {1'b1, 16'h0FA0}, {1'b1, 16'hF060}, {1'b1, 16'h7FFF}, {1'b1, 16'h8000},
    {1'b0, 16'h8000}, {1'b1, 16'h0001}, {1'b1, 16'hFFFF}, {1'b1, 16'h2000},
    {1'b1, 16'h3A98}, {1'b1, 16'hA000}, {1'b0, 16'h5555}, {1'b1, 16'h8000},
    {1'b1, 16'h8000}, {1'b1, 16'h8000}, {1'b1, 16'h7FFF}, {1'b1, 16'h0100},
    {1'b1, 16'hFE00}, {1'b0, 16'h0000}, {1'b1, 16'h6000}, {1'b1, 16'h9000}
  };

  function automatic int sin_ref(input int k);
    real r;
    if (k == 12) return -32768;
    r = 32767.0 * $sin(2.0 * 3.14159265358979 * k / 16.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int clip16(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int mix_ref(input int s, input int c);
    return clip16((s * c) >>> 15);
  endfunction

  task automatic model_reset();
    m_ph = 0; m_cnt = 0; m_acc_i = 0; m_acc_q = 0; e_i = 0; e_q = 0; e_v = 0;
  endtask

  task automatic model_step(input int s);
    int mi, mq;
    mi = mix_ref(s, sin_ref((m_ph + 4) % 16));
    mq = mix_ref(s, sin_ref(m_ph));
    if (m_cnt == 4) begin
      e_i = clip16((m_acc_i + mi) >>> 1);
      e_q = clip16((m_acc_q + mq) >>> 1);
      e_v = 1; m_acc_i = 0; m_acc_q = 0; m_cnt = 0;
    end else begin
      m_acc_i += mi; m_acc_q += mq; m_cnt++; e_v = 0;
    end
    m_ph = (m_ph + 5) % 16;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // caller sits at a negedge
  task automatic push(input logic v, input logic [15:0] s);
    in_valid = v; in_sample = s;
    if (v) model_step(int'($signed(s))); else e_v = 0;
    @(negedge clk);
    chk(v ? "R5" : "R8", int'(out_valid), int'(e_v));
    chk(e_v ? "R6 I" : "R7 I", int'($signed(out_i)), e_i);
    chk(e_v ? "R6 Q" : "R7 Q", int'($signed(out_q)), e_q);
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; in_sample = '0;
    @(negedge clk); @(negedge clk);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 I", int'(out_i), 0);
    chk("R1 Q", int'(out_q), 0);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    chk("R1 after", int'(out_valid), 0);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_sample = '0;
    do_reset();

    // table walk against the model (R5..R8)
    for (int n = 0; n < 24; n++) push(VEC[n][16], VEC[n][15:0]);
    push(1'b0, 16'h1111);

    // R2, R4: lone sample at phase 5: I=-3135, Q=7568
    do_reset();
    push(1'b1, 16'h0000); push(1'b1, 16'h4000); push(1'b1, 16'h0000);
    push(1'b1, 16'h0000); push(1'b1, 16'h0000);
    chk("R2 R4 I", int'($signed(out_i)), -3135);
    chk("R2 R4 Q", int'($signed(out_q)), 7568);

    // R8: gaps with junk samples do not disturb the group
    do_reset();
    push(1'b0, 16'h7FFF); push(1'b1, 16'h0000); push(1'b0, 16'h8000);
    push(1'b1, 16'h4000); push(1'b0, 16'h1234); push(1'b1, 16'h0000);
    push(1'b1, 16'h0000); push(1'b0, 16'h7FFF); push(1'b1, 16'h0000);
    chk("R8 I", int'($signed(out_i)), -3135);
    chk("R8 Q", int'($signed(out_q)), 7568);

    // R3: 13th sample -32768 meets sine -32768 -> mixer 32767, Q=16383
    do_reset();
    for (int n = 0; n < 12; n++) push(1'b1, 16'h0000);
    push(1'b1, 16'h8000); push(1'b1, 16'h0000); push(1'b1, 16'h0000);
    chk("R3 Q", int'($signed(out_q)), 16383);
    chk("R3 I", int'($signed(out_i)), 0);

    // R9: negative and positive clipping of the I sum
    do_reset();
    push(1'b1, 16'h8000); push(1'b1, 16'h7FFF); push(1'b1, 16'h7FFF);
    push(1'b1, 16'h8000); push(1'b1, 16'h0000);
    chk("R9 neg", int'($signed(out_i)), -32768);
    do_reset();
    push(1'b1, 16'h7FFF); push(1'b1, 16'h8000); push(1'b1, 16'h8000);
    push(1'b1, 16'h7FFF); push(1'b1, 16'h0000);
    chk("R9 pos", int'($signed(out_i)), 32767);

    // R1: reset mid-group clears counter and phase
    push(1'b1, 16'h4000); push(1'b1, 16'h4000);
    do_reset();
    push(1'b1, 16'h0000); push(1'b1, 16'h4000); push(1'b1, 16'h0000);
    push(1'b1, 16'h0000); push(1'b1, 16'h0000);
    chk("R1 restart", int'($signed(out_q)), 7568);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule